// File: doc/BRIEF.md
# Subtract-From Integer Execute Unit

This unit executes a reversed-operand integer subtraction in one pipeline stage. On every clock edge it samples a 32-bit instruction word, two source operand values and the incoming overflow, summary-overflow and carry status bits. It decodes the word, computes the second operand minus the first as an invert-plus-one addition, and registers the outputs.

The registered outputs are:

- the destination value with its register index and a write strobe;
- the next overflow, summary-overflow and carry bits;
- a 4-bit condition field with its own update strobe.

Two bits of the instruction gate the updates separately. One bit enables the overflow update. The other enables the condition-field update. Summary-overflow can only be set by this instruction, never cleared.

A word that is not this instruction is not executed. The unit then raises an invalid flag so the surrounding pipeline can take the illegal-instruction path. In that case it passes the status bits through unchanged.

Top module: `subf_exec_unit`

## Requirements
- R1: A word is recognised when bits [31:26] equal 31 and bits [9:1] equal 40 (0x7C000050 with both flag bits clear). One clock after a recognised word is sampled, `rd_we_o` is 1 and `rd_idx_o` holds word bits [25:21]. `src_a_idx_o` holds bits [20:16] and `src_b_idx_o` holds bits [15:11].
- R2: For a recognised word, `rd_data_o` one clock later equals B minus A, computed as ~A + B + 1 and wrapped to DATA_W bits. The destination is written whatever the flag bits are.
- R3: `ca_o` always equals the `ca_i` sampled on the previous clock. This instruction never alters the carry bit.
- R4: When word bit [10] is 1, `ov_o` is the MSB of ((A^B)&(B^result)), and `so_o` is `so_i` OR that overflow bit.
- R5: When word bit [10] is 0, `ov_o` and `so_o` equal the sampled `ov_i` and `so_i`.
- R6: When word bit [0] is 1, `cr0_we_o` is 1 and `cr0_o` = {LT, GT, EQ, SO}, from bit 3 down to bit 0. LT, GT and EQ come from a signed compare of the result with zero. SO is the summary-overflow value after this instruction's own update. When bit [0] is 0, `cr0_we_o` is 0 and `cr0_o` is 0.
- R7: Signed overflow never raises `illegal_o` and never suppresses the destination write.
- R8: For a word that is not recognised:
  - `illegal_o` is 1 and `rd_we_o` and `cr0_we_o` are 0;
  - `rd_data_o` and `cr0_o` are 0;
  - `ov_o`, `so_o` and `ca_o` equal the sampled inputs.
- R9: While `rst` is high at a clock edge, every output is driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word |
| src_a_i | input | DATA_W | Operand A (subtrahend) |
| src_b_i | input | DATA_W | Operand B (minuend) |
| ov_i | input | 1 | Current overflow bit |
| so_i | input | 1 | Current summary-overflow bit |
| ca_i | input | 1 | Current carry bit |
| rd_idx_o | output | 5 | Destination register index |
| src_a_idx_o | output | 5 | Register specifier of operand A |
| src_b_idx_o | output | 5 | Register specifier of operand B |
| rd_data_o | output | DATA_W | Result B minus A |
| rd_we_o | output | 1 | Destination write strobe |
| ov_o | output | 1 | Next overflow bit |
| so_o | output | 1 | Next summary-overflow bit |
| ca_o | output | 1 | Next carry bit (pass-through) |
| cr0_o | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr0_we_o | output | 1 | Condition field update strobe |
| illegal_o | output | 1 | Word not recognised |

## Verification
The hardest outcome to reach from the ports is a signed overflow. Random operands reach it only occasionally, and they almost never reach it at the extremes, where A is the most negative value with B zero, or B is the most positive value with A minus one. It is harder still to reach it together with each pairing of the two flag bits and with summary-overflow entering both set and clear. The stimulus therefore sweeps those extreme operand pairs and equal operands across all four flag combinations and both summary-overflow input values. It then adds a random stream and near-miss words that differ from the recognised encoding in a single opcode field.

// File: rtl/subf_pkg.sv
package subf_pkg;

    localparam int          WORD_W     = 32;
    localparam int          REG_IDX_W  = 5;
    localparam logic [5:0]  PRIMARY_OP = 6'd31;
    localparam logic [8:0]  EXTEND_OP  = 9'd40;

    typedef struct packed {
        logic                   hit;
        logic                   oe;
        logic                   rc;
        logic [REG_IDX_W-1:0]   rd;
        logic [REG_IDX_W-1:0]   ra;
        logic [REG_IDX_W-1:0]   rb;
    } subf_dec_t;

    typedef struct packed {
        logic ov;
        logic so;
        logic ca;
    } stat_bits_t;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    function automatic subf_dec_t crack_word(input logic [WORD_W-1:0] w);
        subf_dec_t d;
        d.hit = (w[31:26] == PRIMARY_OP) && (w[9:1] == EXTEND_OP);
        d.oe  = w[10];
        d.rc  = w[0];
        d.rd  = w[25:21];
        d.ra  = w[20:16];
        d.rb  = w[15:11];
        return d;
    endfunction

endpackage

// File: rtl/subf_decode.sv
module subf_decode
    import subf_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output subf_dec_t         dec_o
);
    always_comb begin
        dec_o = crack_word(word_i);
    end
endmodule

// File: rtl/subf_arith.sv
module subf_arith #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] diff_o,
    output logic              ovf_o,
    output logic              neg_o,
    output logic              zero_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] a_inv;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] sign_mix;

    always_comb begin
        a_inv    = ~a_i;
        sum      = a_inv + b_i + {{(DATA_W-1){1'b0}}, 1'b1};
        sign_mix = (a_i ^ b_i) & (b_i ^ sum);
        diff_o   = sum;
        ovf_o    = sign_mix[MSB];
        neg_o    = sum[MSB];
        zero_o   = (sum == '0);
    end

    // R2: independent subtract reference
    always_comb begin
        a_r2_diff_matches : assert (diff_o == b_i - a_i);
    end
endmodule

// File: rtl/subf_status.sv
module subf_status
    import subf_pkg::*;
(
    input  subf_dec_t  dec_i,
    input  logic       ovf_i,
    input  logic       neg_i,
    input  logic       zero_i,
    input  stat_bits_t stat_i,
    output stat_bits_t stat_o,
    output cond_t      cond_o,
    output logic       cond_we_o
);
    logic ov_next;
    logic so_next;

    always_comb begin
        ov_next = stat_i.ov;
        so_next = stat_i.so;
        if (dec_i.hit && dec_i.oe) begin
            ov_next = ovf_i;
            so_next = stat_i.so | ovf_i;
        end
        stat_o.ov = ov_next;
        stat_o.so = so_next;
        stat_o.ca = stat_i.ca;
    end

    always_comb begin
        cond_we_o = dec_i.hit && dec_i.rc;
        cond_o    = '0;
        if (cond_we_o) begin
            cond_o.lt = neg_i;
            cond_o.gt = !neg_i && !zero_i;
            cond_o.eq = zero_i;
            cond_o.so = so_next;
        end
    end

    // R4: summary-overflow never falls while executing
    always_comb begin
        a_r4_so_not_cleared : assert (!(stat_i.so && !stat_o.so));
    end
endmodule

// File: rtl/subf_exec_unit.sv
module subf_exec_unit
    import subf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [31:0]          insn_i,
    input  logic [DATA_W-1:0]    src_a_i,
    input  logic [DATA_W-1:0]    src_b_i,
    input  logic                 ov_i,
    input  logic                 so_i,
    input  logic                 ca_i,
    output logic [4:0]           rd_idx_o,
    output logic [4:0]           src_a_idx_o,
    output logic [4:0]           src_b_idx_o,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic                 rd_we_o,
    output logic                 ov_o,
    output logic                 so_o,
    output logic                 ca_o,
    output logic [3:0]           cr0_o,
    output logic                 cr0_we_o,
    output logic                 illegal_o
);
    subf_dec_t          dec;
    logic [DATA_W-1:0]  diff;
    logic               ovf;
    logic               neg;
    logic               zero;
    stat_bits_t         stat_in;
    stat_bits_t         stat_nx;
    cond_t              cond_nx;
    logic               cond_we_nx;
    logic               past_ok;

    assign stat_in = '{ov: ov_i, so: so_i, ca: ca_i};

    subf_decode u_dec (
        .word_i (insn_i),
        .dec_o  (dec)
    );

    subf_arith #(.DATA_W(DATA_W)) u_alu (
        .a_i    (src_a_i),
        .b_i    (src_b_i),
        .diff_o (diff),
        .ovf_o  (ovf),
        .neg_o  (neg),
        .zero_o (zero)
    );

    subf_status u_stat (
        .dec_i     (dec),
        .ovf_i     (ovf),
        .neg_i     (neg),
        .zero_i    (zero),
        .stat_i    (stat_in),
        .stat_o    (stat_nx),
        .cond_o    (cond_nx),
        .cond_we_o (cond_we_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx_o    <= '0;
            src_a_idx_o <= '0;
            src_b_idx_o <= '0;
            rd_data_o   <= '0;
            rd_we_o     <= 1'b0;
            ov_o        <= 1'b0;
            so_o        <= 1'b0;
            ca_o        <= 1'b0;
            cr0_o       <= '0;
            cr0_we_o    <= 1'b0;
            illegal_o   <= 1'b0;
            past_ok     <= 1'b0;
        end else begin
            rd_idx_o    <= dec.rd;
            src_a_idx_o <= dec.ra;
            src_b_idx_o <= dec.rb;
            rd_data_o   <= dec.hit ? diff : '0;
            rd_we_o     <= dec.hit;
            ov_o        <= stat_nx.ov;
            so_o        <= stat_nx.so;
            ca_o        <= stat_nx.ca;
            cr0_o       <= cond_nx;
            cr0_we_o    <= cond_we_nx;
            illegal_o   <= !dec.hit;
            past_ok     <= 1'b1;
        end
    end

    a_r2_registered_result : assert property (@(posedge clk) disable iff (rst)
        (past_ok && rd_we_o) |-> (rd_data_o == $past(src_b_i) - $past(src_a_i)));

    a_r3_carry_passes : assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (ca_o == $past(ca_i)));

    a_r4_so_sticky : assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(so_i)) |-> so_o);

    a_r5_status_hold : assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(insn_i[10])) |-> (ov_o == $past(ov_i) && so_o == $past(so_i)));

    a_r6_cond_so_copy : assert property (@(posedge clk) disable iff (rst)
        cr0_we_o |-> (cr0_o[0] == so_o));

    a_r6_cond_one_relation : assert property (@(posedge clk) disable iff (rst)
        cr0_we_o |-> ($countones(cr0_o[3:1]) == 1));

    a_r7_no_trap : assert property (@(posedge clk) disable iff (rst)
        (rd_we_o && ov_o) |-> !illegal_o);

    a_r8_illegal_quiet : assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!rd_we_o && !cr0_we_o));

    a_r1_strobe_excl : assert property (@(posedge clk) disable iff (rst)
        past_ok |-> $onehot({rd_we_o, illegal_o}));
endmodule

// File: tb/subf_exec_unit_tb_top.sv
module subf_exec_unit_tb_top;
    localparam int DW = 32;

    typedef struct {
        logic [4:0]    rd;
        logic [DW-1:0] data;
        logic          we;
        logic          ov;
        logic          so;
        logic          ca;
        logic [3:0]    cr;
        logic          cr_we;
        logic          ill;
        logic          oe;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   insn_i = '0;
    logic [DW-1:0] src_a_i = '0;
    logic [DW-1:0] src_b_i = '0;
    logic          ov_i = 1'b0;
    logic          so_i = 1'b0;
    logic          ca_i = 1'b0;
    logic [4:0]    rd_idx_o, src_a_idx_o, src_b_idx_o;
    logic [DW-1:0] rd_data_o;
    logic          rd_we_o, ov_o, so_o, ca_o, cr0_we_o, illegal_o;
    logic [3:0]    cr0_o;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    subf_exec_unit #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .insn_i(insn_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
        .ov_i(ov_i), .so_i(so_i), .ca_i(ca_i), .rd_idx_o(rd_idx_o),
        .src_a_idx_o(src_a_idx_o), .src_b_idx_o(src_b_idx_o), .rd_data_o(rd_data_o),
        .rd_we_o(rd_we_o), .ov_o(ov_o), .so_o(so_o), .ca_o(ca_o), .cr0_o(cr0_o),
        .cr0_we_o(cr0_we_o), .illegal_o(illegal_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(input logic [4:0] rd, input logic oe, input logic rc);
        return {6'd31, rd, 5'd3, 5'd4, oe, 9'd40, rc};
    endfunction

    task automatic drive(input logic [31:0] w, input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic ov, input logic so, input logic ca);
        exp_t e;
        longint sd;
        logic [DW-1:0] r;
        logic hit, ovf, so_n;
        @(negedge clk);
        insn_i = w; src_a_i = a; src_b_i = b; ov_i = ov; so_i = so; ca_i = ca;
        hit  = (w[31:26] == 6'd31) && (w[9:1] == 9'd40);
        r    = b - a;
        sd   = longint'($signed(b)) - longint'($signed(a));
        ovf  = (sd != longint'($signed(r)));
        so_n = (hit && w[10]) ? (so | ovf) : so;
        e.rd    = w[25:21];
        e.data  = hit ? r : '0;
        e.we    = hit;
        e.ov    = (hit && w[10]) ? ovf : ov;
        e.so    = so_n;
        e.ca    = ca;
        e.cr_we = hit && w[0];
        e.cr    = e.cr_we ? {$signed(r) < 0, $signed(r) > 0, r == '0, so_n} : 4'b0;
        e.ill   = !hit;
        e.oe    = hit && w[10];
        sb_q.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check("R1 rd_we", 64'(rd_we_o), 64'(e.we));
            if (e.we) check("R1 rd_idx", 64'(rd_idx_o), 64'(e.rd));
            check("R2 result", 64'(rd_data_o), 64'(e.data));
            check("R3 carry", 64'(ca_o), 64'(e.ca));
            check(e.oe ? "R4 ov" : "R5 ov", 64'(ov_o), 64'(e.ov));
            check(e.oe ? "R4 so" : "R5 so", 64'(so_o), 64'(e.so));
            check("R6 cr0_we", 64'(cr0_we_o), 64'(e.cr_we));
            check("R6 cr0", 64'(cr0_o), 64'(e.cr));
            check(e.ill ? "R8 illegal" : "R7 illegal", 64'(illegal_o), 64'(e.ill));
        end
    end

    task automatic finish_report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_report();
        end
    end

    initial begin
        logic [DW-1:0] mn, mx;
        mn = {1'b1, {(DW-1){1'b0}}};
        mx = {1'b0, {(DW-1){1'b1}}};
        insn_i = mk_word(5'd7, 1'b1, 1'b1); ov_i = 1'b1; so_i = 1'b1; ca_i = 1'b1;
        src_a_i = 5; src_b_i = 9;
        repeat (3) @(posedge clk);
        #2;
        // R9 reset state
        check("R9 reset", {rd_data_o, 5'b0, rd_we_o, ov_o, so_o, ca_o, cr0_o, cr0_we_o, illegal_o,
                           rd_idx_o, 7'b0}, 64'd0);
        @(negedge clk); rst = 1'b0;
        check("R1 encoding", 64'(mk_word(5'd0, 1'b0, 1'b0) & 32'hFC0007FF), 64'h7C000050);
        for (int f = 0; f < 4; f++) begin
            for (int s = 0; s < 2; s++) begin
                drive(mk_word(5'(f + 1), f[1], f[0]), mn, '0, 1'b0, s[0], s[0]);
                drive(mk_word(5'(f + 9), f[1], f[0]), '1, mx, 1'b1, s[0], 1'b0);
                drive(mk_word(5'd31, f[1], f[0]), 32'h1234_5678, 32'h1234_5678, 1'b1, s[0], 1'b1);
                drive(mk_word(5'd2, f[1], f[0]), 32'd10, 32'd3, 1'b0, s[0], 1'b0);
                drive(mk_word(5'd3, f[1], f[0]), 32'd3, 32'd10, 1'b1, s[0], 1'b1);
            end
        end
        drive(32'h7C000052, 1, 2, 1'b1, 1'b0, 1'b1);   // R8 extended op 41
        drive(32'h78000451, 1, 2, 1'b0, 1'b1, 1'b0);   // R8 primary op 30
        drive(32'h0, 1, 2, 1'b1, 1'b1, 1'b1);          // R8 zero word
        for (int i = 0; i < 300; i++) begin
            logic [31:0] w;
            w = mk_word(5'($urandom), 1'($urandom), 1'($urandom));
            if (i % 10 == 9) w[9:1] = 9'($urandom);
            drive(w, $urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_report();
    end
endmodule